// File: doc/BRIEF.md
# Load/Store Port with Local Byte Memory

This block is the memory-facing end of a processor's load/store unit. It accepts one load or one store at a time over a split-phase handshake and serves it from a small local memory. The memory is 64 bits wide and addressed in bytes. The requester first presents the operation type, an access length, a privilege bit and an address. The port acknowledges the address with a one-cycle pulse.

A store then supplies its data as a one-cycle strobe, and the port writes only the addressed bytes. A load returns its bytes right-aligned and zero-extended. A load ends with either a data-valid or an exception indication, which stays up until the requester drops its load flag.

An access whose bytes would run past an aligned 8-byte word is refused with the exception flag. A store that carries the block-zero flag clears the whole aligned 64-byte block around its address, one word per cycle, while busy stays high.

Top module: `lsport_mem`

## Requirements
- R1: During and right after reset, busy, addrAck, ldValid and excHappened are all 0.
- R2: While busy is 0, a request is taken on a clock edge where addrValid is 1 together with reqLoad or reqStore (load wins when both are set). addrAck is then 1 for exactly the next cycle, and busy rises in that same cycle. A load or store flag without addrValid is not taken.
- R3: A store's data is taken on the edge where stValid is 1, either in the addrAck cycle or later. Only the addressed bytes change. busy reads 0 two cycles after the strobe was driven.
- R4: A load shows ldValid 1 in the third cycle after the request is taken. ldData holds the addressed bytes right-aligned and zero-extended to 64 bits. ldValid and ldData stay unchanged while reqLoad remains 1, and busy falls in the cycle after reqLoad drops.
- R5: Bytes are little-endian across addresses. The byte at address A lands in ldData[7:0] and the byte at A+1 in ldData[15:8].
- R6: accLen codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes for both loads and stores.
- R7: An access with (address mod 8) + length > 8 raises excHappened. For a load, ldValid stays 0 and ldData is 0. For a store, nothing is written, busy is 0 one cycle after the strobe, and excHappened holds until reqStore drops.
- R8: A store with reqZero set writes zeros to all 64 bytes of the aligned 64-byte block that holds its address, ignoring accLen and alignment. busy reads 0 nine cycles after the strobe.
- R9: privMode has no effect on any stored or loaded value.
- R10: After a store has finished, busy is 0, but no new request is taken until reqStore has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqLoad | input | 1 | Load request flag |
| reqStore | input | 1 | Store request flag |
| reqZero | input | 1 | With reqStore: zero the enclosing 64-byte block |
| accLen | input | 2 | Access length code: 0/1/2/3 = 1/2/4/8 bytes |
| privMode | input | 1 | 1 = virtual-mode access, 0 = real-mode; no effect on data |
| addrIn | input | ADDR_W | Byte address |
| addrValid | input | 1 | Address valid |
| stData | input | 64 | Store data, right-aligned |
| stValid | input | 1 | One-cycle store data strobe |
| ldData | output | 64 | Load data, right-aligned, zero-extended |
| ldValid | output | 1 | Load data valid, held until reqLoad drops |
| excHappened | output | 1 | Access refused for crossing a word boundary |
| busy | output | 1 | Port is working on a request |
| addrAck | output | 1 | One-cycle address-accepted pulse |

## Verification
A control state that is off by one or stuck shows up at once in the handshake timing. It moves the addrAck cycle, the cycle ldValid appears, or the number of cycles busy stays high after the strobe, and all of these are measured against the exact counts in the requirements. A wrong byte mask, shift or zeroing index leaves no mark on the handshake. It appears only when the affected bytes are loaded back. For that reason every load is compared with a byte-level model, and random traffic revisits the same 512 bytes many times, so a corrupted byte is reported within a few transactions of the bad write.

// File: rtl/lsport_pkg.sv
package lsport_pkg;

  localparam int WORD_BYTES = 8;
  localparam int WORD_W     = 64;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACK, ST_STWAIT, ST_WRITE, ST_ZERO, ST_STHOLD, ST_LDALIGN, ST_LDRESP
  } lsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;   // latch request fields
    logic rdEn;     // read addressed word
    logic capSt;    // latch store data
    logic ldCap;    // produce aligned load result
    logic wrEn;     // byte-masked write
    logic zeroEn;   // clear one word of the block
  } lsStrobe_t;

  function automatic logic [3:0] lenBytes(input logic [1:0] len);
    return 4'd1 << len;
  endfunction

  function automatic logic crossesWord(input logic [1:0] len, input logic [2:0] off);
    return ({1'b0, off} + lenBytes(len)) > 4'd8;
  endfunction

endpackage

// File: rtl/lsport_ctrl.sv
module lsport_ctrl
  import lsport_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqLoad,
  input  logic      reqStore,
  input  logic      addrValid,
  input  logic      stValid,
  input  logic      misaligned,
  input  logic      zeroReq,
  input  logic      zeroLast,
  output lsStrobe_t stb,
  output logic      busy,
  output logic      addrAck,
  output logic      ldValid,
  output logic      excHappened
);

  lsState_t state, stateNxt;
  logic isLoadQ, excQ, excSet;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    excSet   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (addrValid && (reqLoad || reqStore)) begin
          stb.capReq = 1'b1;
          stateNxt   = ST_ACK;
        end
      end
      ST_ACK, ST_STWAIT: begin
        if (state == ST_ACK && isLoadQ) begin
          stb.rdEn = 1'b1;
          excSet   = misaligned;
          stateNxt = ST_LDALIGN;
        end else if (stValid) begin
          stb.capSt = 1'b1;
          if (zeroReq)         stateNxt = ST_ZERO;
          else if (misaligned) begin
            excSet   = 1'b1;
            stateNxt = ST_STHOLD;
          end else             stateNxt = ST_WRITE;
        end else begin
          stateNxt = ST_STWAIT;
        end
      end
      ST_WRITE: begin
        stb.wrEn = 1'b1;
        stateNxt = ST_STHOLD;
      end
      ST_ZERO: begin
        stb.zeroEn = 1'b1;
        if (zeroLast) stateNxt = ST_STHOLD;
      end
      ST_STHOLD: begin
        if (!reqStore) stateNxt = ST_IDLE;
      end
      ST_LDALIGN: begin
        stb.ldCap = 1'b1;
        stateNxt  = ST_LDRESP;
      end
      ST_LDRESP: begin
        if (!reqLoad) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isLoadQ <= 1'b0;
      excQ    <= 1'b0;
    end else begin
      state <= stateNxt;
      if (stb.capReq) begin
        isLoadQ <= reqLoad;
        excQ    <= 1'b0;
      end else if (excSet) begin
        excQ <= 1'b1;
      end
    end
  end

  assign busy        = !(state == ST_IDLE || state == ST_STHOLD);
  assign addrAck     = (state == ST_ACK);
  assign ldValid     = (state == ST_LDRESP) && !excQ;
  assign excHappened = (state == ST_LDRESP || state == ST_STHOLD) && excQ;

endmodule

// File: rtl/lsport_datapath.sv
module lsport_datapath
  import lsport_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int MEM_WORDS   = 64,
  parameter int BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsStrobe_t         stb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [1:0]        accLen,
  input  logic              reqLoad,
  input  logic              reqZero,
  input  logic              privMode,
  input  logic [WORD_W-1:0] stData,
  output logic              misaligned,
  output logic              zeroReq,
  output logic              zeroLast,
  output logic [WORD_W-1:0] ldData
);

  localparam int IDX_W     = $clog2(MEM_WORDS);
  localparam int BLK_WORDS = BLOCK_BYTES / WORD_BYTES;
  localparam int BLK_W     = $clog2(BLK_WORDS);

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        lenQ;
  logic              zeroQ;
  logic [WORD_W-1:0] stDataQ, readWordQ, ldDataQ;
  logic [BLK_W-1:0]  zeroCnt;
  logic [WORD_W-1:0] mem [MEM_WORDS];

  logic [2:0]        offset;
  logic [IDX_W-1:0]  wordIdx, zeroIdx;
  logic [7:0]        laneMask;
  logic [WORD_W-1:0] shiftedSt, oldWord, mergedWord, lenMask64, alignedLd;

  assign offset  = addrQ[2:0];
  assign wordIdx = addrQ[IDX_W+2:3];
  assign zeroIdx = {addrQ[IDX_W+2:3+BLK_W], zeroCnt};

  always_comb begin
    unique case (lenQ)
      2'd0: lenMask64 = 64'h0000_0000_0000_00FF;
      2'd1: lenMask64 = 64'h0000_0000_0000_FFFF;
      2'd2: lenMask64 = 64'h0000_0000_FFFF_FFFF;
      default: lenMask64 = '1;
    endcase
  end

  assign laneMask  = 8'((16'h00FF >> (4'd8 - lenBytes(lenQ))) << offset);
  assign shiftedSt = stDataQ << {offset, 3'b000};
  assign oldWord   = mem[wordIdx];
  assign alignedLd = (readWordQ >> {offset, 3'b000}) & lenMask64;

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    assign mergedWord[8*b +: 8] = laneMask[b] ? shiftedSt[8*b +: 8] : oldWord[8*b +: 8];
  end

  // storage: no reset
  always_ff @(posedge clk) begin
    if (stb.wrEn)   mem[wordIdx] <= mergedWord;
    if (stb.zeroEn) mem[zeroIdx] <= '0;
    if (stb.rdEn)   readWordQ    <= mem[wordIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      lenQ    <= '0;
      zeroQ   <= 1'b0;
      stDataQ <= '0;
      ldDataQ <= '0;
      zeroCnt <= '0;
    end else begin
      if (stb.capReq) begin
        addrQ   <= addrIn;
        lenQ    <= accLen;
        zeroQ   <= reqZero && !reqLoad;
        zeroCnt <= '0;
      end
      if (stb.capSt)  stDataQ <= stData;
      if (stb.zeroEn) zeroCnt <= zeroCnt + 1'b1;
      if (stb.ldCap)  ldDataQ <= misaligned ? '0 : alignedLd;
    end
  end

  // privilege and high address bits take no part in the data path
  logic unusedBits;
  assign unusedBits = ^{privMode, addrQ[ADDR_W-1:IDX_W+3]};

  assign misaligned = crossesWord(lenQ, offset);
  assign zeroReq    = zeroQ;
  assign zeroLast   = (zeroCnt == BLK_W'(BLK_WORDS - 1));
  assign ldData     = ldDataQ;

endmodule

// File: rtl/lsport_mem.sv
module lsport_mem
  import lsport_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int MEM_WORDS   = 64,
  parameter int BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqLoad,
  input  logic              reqStore,
  input  logic              reqZero,
  input  logic [1:0]        accLen,
  input  logic              privMode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              addrValid,
  input  logic [63:0]       stData,
  input  logic              stValid,
  output logic [63:0]       ldData,
  output logic              ldValid,
  output logic              excHappened,
  output logic              busy,
  output logic              addrAck
);

  lsStrobe_t stb;
  logic misaligned, zeroReq, zeroLast;

  lsport_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqLoad(reqLoad), .reqStore(reqStore),
    .addrValid(addrValid), .stValid(stValid), .misaligned(misaligned),
    .zeroReq(zeroReq), .zeroLast(zeroLast), .stb(stb), .busy(busy),
    .addrAck(addrAck), .ldValid(ldValid), .excHappened(excHappened)
  );

  lsport_datapath #(
    .ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS), .BLOCK_BYTES(BLOCK_BYTES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .addrIn(addrIn), .accLen(accLen),
    .reqLoad(reqLoad), .reqZero(reqZero), .privMode(privMode), .stData(stData),
    .misaligned(misaligned), .zeroReq(zeroReq), .zeroLast(zeroLast), .ldData(ldData)
  );

endmodule

// File: rtl/lsport_mem_chk.sv
module lsport_mem_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqLoad,
  input logic [63:0] ldData,
  input logic        ldValid,
  input logic        excHappened,
  input logic        busy,
  input logic        addrAck
);

  AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |=> !addrAck);  // R2

  AST_BUSY_RISES_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> addrAck);  // R2

  AST_LD_VALID_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && reqLoad) |=> (ldValid && $stable(ldData)));  // R4

  AST_LD_VALID_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(ldValid && excHappened));  // R7

  AST_EXC_LOAD_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (excHappened && reqLoad) |-> (ldData == 64'd0));  // R7

endmodule

bind lsport_mem lsport_mem_chk chk_i (
  .clk(clk), .rstN(rstN), .reqLoad(reqLoad), .ldData(ldData), .ldValid(ldValid),
  .excHappened(excHappened), .busy(busy), .addrAck(addrAck)
);

// File: tb/lsport_mem_tb_top.sv
`timescale 1ns/1ps
module lsport_mem_tb_top;

  localparam int ADDR_W    = 16;
  localparam int MEM_BYTES = 512;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqLoad, reqStore, reqZero, privMode, addrValid, stValid;
  logic [1:0]  accLen;
  logic [15:0] addrIn;
  logic [63:0] stData, ldData;
  logic        ldValid, excHappened, busy, addrAck;

  logic [7:0]  model [MEM_BYTES];
  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  lsport_mem #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqLoad(reqLoad), .reqStore(reqStore), .reqZero(reqZero),
    .accLen(accLen), .privMode(privMode), .addrIn(addrIn), .addrValid(addrValid),
    .stData(stData), .stValid(stValid), .ldData(ldData), .ldValid(ldValid),
    .excHappened(excHappened), .busy(busy), .addrAck(addrAck)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit crosses(input logic [15:0] a, input logic [1:0] len);
    return (int'(a[2:0]) + (1 << len)) > 8;
  endfunction

  function automatic logic [63:0] modelLoad(input logic [15:0] a, input logic [1:0] len);
    logic [63:0] r = '0;
    if (crosses(a, len)) return '0;
    for (int i = 0; i < (1 << len); i++) r[8*i +: 8] = model[(int'(a) + i) % MEM_BYTES];
    return r;
  endfunction

  task automatic doStore(input logic [15:0] a, input logic [1:0] len, input logic [63:0] d,
                         input bit priv, input bit zero, input int linger);
    int cnt;
    int expCnt = zero ? 9 : (crosses(a, len) ? 1 : 2);
    bit expExc = !zero && crosses(a, len);
    check(busy == 1'b0, "R2", "busy before store", 64'(busy), 64'd0);
    reqStore = 1'b1; reqZero = zero; accLen = len; privMode = priv;
    addrIn = a; addrValid = 1'b1;
    @(negedge clk);
    check(addrAck == 1'b1, "R2", "store addrAck", 64'(addrAck), 64'd1);
    stData = d; stValid = 1'b1;
    @(negedge clk);
    stValid = 1'b0; stData = $urandom;
    cnt = 1;
    while (busy && cnt < 40) begin @(negedge clk); cnt++; end
    if (zero)        check(cnt == expCnt, "R8", "zero busy cycles", 64'(cnt), 64'(expCnt));
    else if (expExc) check(cnt == expCnt, "R7", "exc store busy cycles", 64'(cnt), 64'(expCnt));
    else             check(cnt == expCnt, "R3", "store busy cycles", 64'(cnt), 64'(expCnt));
    check(excHappened == expExc, "R7", "store exception flag", 64'(excHappened), 64'(expExc));
    if (zero) begin
      int base = (int'(a) % MEM_BYTES) & ~63;
      for (int i = 0; i < 64; i++) model[base + i] = 8'h00;
    end else if (!expExc) begin
      for (int i = 0; i < (1 << len); i++) model[(int'(a) + i) % MEM_BYTES] = d[8*i +: 8];
    end
    for (int k = 0; k < linger; k++) begin
      @(negedge clk);
      check(addrAck == 1'b0 && busy == 1'b0, "R10", "stale store flag taken",
            {62'd0, addrAck, busy}, 64'd0);
    end
    reqStore = 1'b0; addrValid = 1'b0; reqZero = 1'b0;
    @(negedge clk);
    check(excHappened == 1'b0 && busy == 1'b0, "R7", "exc cleared after store",
          {62'd0, excHappened, busy}, 64'd0);
  endtask

  task automatic doLoad(input logic [15:0] a, input logic [1:0] len, input bit priv,
                        output logic [63:0] got);
    int cnt;
    logic [63:0] expD = modelLoad(a, len);
    bit expExc = crosses(a, len);
    check(busy == 1'b0, "R2", "busy before load", 64'(busy), 64'd0);
    reqLoad = 1'b1; accLen = len; privMode = priv; addrIn = a; addrValid = 1'b1;
    @(negedge clk);
    check(addrAck == 1'b1, "R2", "load addrAck", 64'(addrAck), 64'd1);
    cnt = 1;
    while (!(ldValid || excHappened) && cnt < 40) begin @(negedge clk); cnt++; end
    check(cnt == 3, "R4", "load response cycle", 64'(cnt), 64'd3);
    check(ldValid == !expExc && excHappened == expExc, "R7", "load valid/exc",
          {62'd0, ldValid, excHappened}, {62'd0, !expExc, expExc});
    check(ldData == expD, expExc ? "R7" : "R4", "load data", ldData, expD);
    got = ldData;
    @(negedge clk);
    check(ldData == expD && ldValid == !expExc, "R4", "load response held", ldData, expD);
    reqLoad = 1'b0; addrValid = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && ldValid == 1'b0, "R4", "load release",
          {62'd0, busy, ldValid}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [63:0] got;
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqLoad = 0; reqStore = 0; reqZero = 0; privMode = 0;
    addrValid = 0; stValid = 0; accLen = 0; addrIn = '0; stData = '0;
    repeat (3) @(negedge clk);
    check({busy, addrAck, ldValid, excHappened} == 4'b0, "R1", "outputs in reset",
          {60'd0, busy, addrAck, ldValid, excHappened}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, addrAck, ldValid, excHappened} == 4'b0, "R1", "outputs after reset",
          {60'd0, busy, addrAck, ldValid, excHappened}, 64'd0);

    // R8: clear every block (odd offsets and lengths are ignored)
    for (int b = 0; b < MEM_BYTES / 64; b++)
      doStore(16'(b * 64 + 7), 2'd3, 64'hDEAD_BEEF_0000_1111, 1'b0, 1'b1, 0);

    // R2: flag without addrValid is not taken
    reqLoad = 1'b1; reqStore = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(busy == 1'b0 && addrAck == 1'b0, "R2", "no addrValid ignored",
            {62'd0, busy, addrAck}, 64'd0);
    end
    reqLoad = 1'b0; reqStore = 1'b0;
    @(negedge clk);

    // R5: two half-word stores read back as one word
    doStore(16'h0010, 2'd1, 64'h1234, 1'b0, 1'b0, 0);
    doStore(16'h0012, 2'd1, 64'hABCD, 1'b0, 1'b0, 0);
    doLoad(16'h0010, 2'd2, 1'b0, got);
    check(got == 64'hABCD_1234, "R5", "little-endian word", got, 64'hABCD_1234);

    // R6: all four lengths
    doStore(16'h0020, 2'd3, 64'h8877_6655_4433_2211, 1'b0, 1'b0, 0);
    doLoad(16'h0020, 2'd0, 1'b0, got);
    check(got == 64'h11, "R6", "1-byte load", got, 64'h11);
    doLoad(16'h0022, 2'd1, 1'b0, got);
    check(got == 64'h4433, "R6", "2-byte load", got, 64'h4433);
    doLoad(16'h0024, 2'd2, 1'b0, got);
    check(got == 64'h8877_6655, "R6", "4-byte load", got, 64'h8877_6655);
    doLoad(16'h0020, 2'd3, 1'b0, got);
    check(got == 64'h8877_6655_4433_2211, "R6", "8-byte load", got, 64'h8877_6655_4433_2211);

    // R7: crossing accesses
    doLoad(16'h0026, 2'd2, 1'b0, got);
    doStore(16'h0027, 2'd1, 64'hFFFF, 1'b0, 1'b0, 0);
    doLoad(16'h0020, 2'd3, 1'b0, got);
    check(got == 64'h8877_6655_4433_2211, "R7", "refused store wrote nothing",
          got, 64'h8877_6655_4433_2211);

    // R8: zero one block, neighbour intact
    doStore(16'h0040, 2'd3, 64'h0102_0304_0506_0708, 1'b0, 1'b0, 0);
    doStore(16'h0080, 2'd3, 64'hCAFE_F00D_0BAD_BEEF, 1'b0, 1'b0, 0);
    doStore(16'h0075, 2'd0, 64'h0, 1'b0, 1'b1, 0);
    doLoad(16'h0040, 2'd3, 1'b0, got);
    check(got == 64'd0, "R8", "block cleared", got, 64'd0);
    doLoad(16'h0080, 2'd3, 1'b0, got);
    check(got == 64'hCAFE_F00D_0BAD_BEEF, "R8", "next block kept", got, 64'hCAFE_F00D_0BAD_BEEF);

    // R9: privilege does not alter data
    doStore(16'h0100, 2'd2, 64'h5A5A_A5A5, 1'b1, 1'b0, 0);
    doLoad(16'h0100, 2'd2, 1'b0, got);
    check(got == 64'h5A5A_A5A5, "R9", "virt store, real load", got, 64'h5A5A_A5A5);
    doLoad(16'h0100, 2'd2, 1'b1, got);
    check(got == 64'h5A5A_A5A5, "R9", "virt load", got, 64'h5A5A_A5A5);

    // R10: lingering store flags
    doStore(16'h0108, 2'd0, 64'h77, 1'b0, 1'b0, 3);
    doLoad(16'h0108, 2'd0, 1'b0, got);

    // random traffic (R3, R4, R6, R7, R9)
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a = 16'($urandom);
      logic [1:0]  len = 2'($urandom);
      bit          priv = 1'($urandom);
      int          op = $urandom % 16;
      if (op < 7)       doStore(a, len, {$urandom, $urandom}, priv, 1'b0, $urandom % 2);
      else if (op == 7) doStore(a, len, 64'd0, priv, 1'b1, 0);
      else              doLoad(a, len, priv, got);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule